// File: doc/BRIEF.md
# Eight-Channel Two-Phase Reload PWM Timer

This block holds eight independent down-counters behind a small word-wide register port. Software sets each channel up through its own configuration word and two reload values. The first reload value times the low phase of the channel output and the second times the high phase. Once a channel is started, its counter steps down by one on every clock. When it reaches zero it reloads, and in waveform mode the output flips at that reload. A channel started from the stopped state always opens with its low phase.

Each channel also shows its live count, a masked interrupt status and a read-to-clear acknowledge location. Bank-wide locations return the masked and raw interrupt vectors, acknowledge all channels at once, and return a fixed version word. Register offsets are fixed, because software decodes them. Reads are combinational from the address. An acknowledge takes effect on the clock edge at which the read strobe is high.

Top module: `pwmt_bank`

## Requirements
- R1: After reset every register, count and interrupt bit is zero, every readable location except the version word returns zero, and every `pwmOut` bit is low.
- R2: The first reload value of channel n is read and written at byte offset n*0x14 and the second at 0xb0 + 4*n. Bits [CNT_W-1:0] of the write data are stored and read back unchanged.
- R3: A write of 1 to bit 0 (run) of the configuration word at n*0x14+0x08, made while the channel is stopped, loads the count from the first reload value at that clock edge and puts the output in its low phase. From the next edge the count at n*0x14+0x04 falls by one per clock.
- R4: With bit 1 (reload-from-registers) and bit 3 (waveform) both set, `pwmOut[n]` stays low for first-reload+1 clocks, then high for second-reload+1 clocks, and keeps alternating, including when a reload value is 0.
- R5: At zero with bit 1 set and bit 3 clear, the count reloads from the first reload value. At zero with bit 1 clear, it reloads to all ones.
- R6: A stopped channel holds its count and drives `pwmOut[n]` low. A configuration write that keeps bit 0 at 1 on a running channel does not reload the count.
- R7: A running channel that reaches zero sets its raw interrupt bit. The raw vector is read at 0xa8, with bit n for channel n.
- R8: Bit 2 of the configuration word masks channel n. Its status at n*0x14+0x10 (bit 0) and bit n of the vector at 0xa0 show raw AND NOT mask.
- R9: A read of n*0x14+0x0c clears only the raw bit of channel n. A read of 0xa4 clears the raw bits of all channels. Both locations return zero.
- R10: Offset 0xac returns the VERSION parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wrEn | input | 1 | Write strobe, one word per clock |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read strobe; activates the read-to-clear side effects |
| rdData | output | DATA_W | Read data, combinational from `addr` |
| pwmOut | output | NUM_CH | Waveform output per channel |

## Verification
A wrong count or phase state shows on the waveform pin within one phase. A bad reload value makes that phase one clock longer or shorter on the very next cycle, and an inverted phase flag makes the channel start high. A stale raw bit, or one cleared by mistake, shows in the raw and masked vectors on the next read after the event. The live count location exposes a missed hold or a wrong reload source within a clock of the zero crossing.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  parameter int NUM_CH = 8;

  // per-channel offsets inside a 0x14 window, fixed for software
  localparam int STRIDE   = 20;
  localparam int OFS_CUR  = 4;
  localparam int OFS_CTL  = 8;
  localparam int OFS_ACK  = 12;
  localparam int OFS_STS  = 16;
  localparam int LD2_BASE = 176;
  localparam int G_STS    = 160;
  localparam int G_ACK    = 164;
  localparam int G_RAW    = 168;
  localparam int G_VER    = 172;

  // configuration bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_USER = 1;
  localparam int CB_MASK = 2;
  localparam int CB_WAVE = 3;
  localparam int CTL_W   = 4;

  typedef struct packed {
    logic [NUM_CH-1:0] start;
    logic [NUM_CH-1:0] clr;
  } strobe_t;
endpackage

// File: rtl/pwmt_ctrl.sv
module pwmt_ctrl
  import pwmt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter logic [31:0] VERSION = 32'h3230_372a
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               wrEn,
  input  logic [DATA_W-1:0]                  wrData,
  input  logic                               rdEn,
  output logic [DATA_W-1:0]                  rdData,
  input  logic [NUM_CH-1:0][CNT_W-1:0]       cntArr,
  input  logic [NUM_CH-1:0]                  rawVec,
  output logic [NUM_CH-1:0][CNT_W-1:0]       ld1Arr,
  output logic [NUM_CH-1:0][CNT_W-1:0]       ld2Arr,
  output logic [NUM_CH-1:0][CTL_W-1:0]       ctlArr,
  output strobe_t                            strobes
);
  logic [NUM_CH-1:0] stsVec;

  function automatic logic hitAt(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ld1Arr <= '0;
      ld2Arr <= '0;
      ctlArr <= '0;
    end else if (wrEn) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (hitAt(addr, i*STRIDE))            ld1Arr[i] <= wrData[CNT_W-1:0];
        if (hitAt(addr, LD2_BASE + 4*i))      ld2Arr[i] <= wrData[CNT_W-1:0];
        if (hitAt(addr, i*STRIDE + OFS_CTL))  ctlArr[i] <= wrData[CTL_W-1:0];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      strobes.start[i] = wrEn && hitAt(addr, i*STRIDE + OFS_CTL)
                         && wrData[CB_RUN] && !ctlArr[i][CB_RUN];
      strobes.clr[i]   = rdEn && (hitAt(addr, i*STRIDE + OFS_ACK) || hitAt(addr, G_ACK));
      stsVec[i]        = rawVec[i] & ~ctlArr[i][CB_MASK];
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hitAt(addr, i*STRIDE))           rdData = DATA_W'(ld1Arr[i]);
      if (hitAt(addr, i*STRIDE + OFS_CUR)) rdData = DATA_W'(cntArr[i]);
      if (hitAt(addr, i*STRIDE + OFS_CTL)) rdData = DATA_W'(ctlArr[i]);
      if (hitAt(addr, i*STRIDE + OFS_STS)) rdData = DATA_W'(stsVec[i]);
      if (hitAt(addr, LD2_BASE + 4*i))     rdData = DATA_W'(ld2Arr[i]);
    end
    if (hitAt(addr, G_STS)) rdData = DATA_W'(stsVec);
    if (hitAt(addr, G_RAW)) rdData = DATA_W'(rawVec);
    if (hitAt(addr, G_VER)) rdData = DATA_W'(VERSION);
  end
endmodule

// File: rtl/pwmt_datapath.sv
module pwmt_datapath
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CH-1:0][CNT_W-1:0] ld1Arr,
  input  logic [NUM_CH-1:0][CNT_W-1:0] ld2Arr,
  input  logic [NUM_CH-1:0][CTL_W-1:0] ctlArr,
  input  strobe_t                      strobes,
  output logic [NUM_CH-1:0][CNT_W-1:0] cntArr,
  output logic [NUM_CH-1:0]            rawVec,
  output logic [NUM_CH-1:0]            pwmOut
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic phaseHi;
    logic running;
    logic atZero;

    assign running   = ctlArr[g][CB_RUN] && !strobes.start[g];
    assign atZero    = running && (cntArr[g] == '0);
    assign pwmOut[g] = ctlArr[g][CB_RUN] && ctlArr[g][CB_WAVE] && phaseHi;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntArr[g] <= '0;
        phaseHi   <= 1'b0;
      end else if (strobes.start[g]) begin
        cntArr[g] <= ld1Arr[g];
        phaseHi   <= 1'b0;
      end else if (atZero) begin
        if (!ctlArr[g][CB_USER]) begin
          cntArr[g] <= '1;
          phaseHi   <= ctlArr[g][CB_WAVE] ? !phaseHi : 1'b0;
        end else if (ctlArr[g][CB_WAVE] && !phaseHi) begin
          cntArr[g] <= ld2Arr[g];
          phaseHi   <= 1'b1;
        end else begin
          cntArr[g] <= ld1Arr[g];
          phaseHi   <= 1'b0;
        end
      end else if (running) begin
        cntArr[g] <= cntArr[g] - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                rawVec[g] <= 1'b0;
      else if (atZero)          rawVec[g] <= 1'b1;
      else if (strobes.clr[g])  rawVec[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pwmt_bank.sv
module pwmt_bank
  import pwmt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter logic [31:0] VERSION = 32'h3230_372a
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  logic [NUM_CH-1:0][CNT_W-1:0] ld1Arr;
  logic [NUM_CH-1:0][CNT_W-1:0] ld2Arr;
  logic [NUM_CH-1:0][CTL_W-1:0] ctlArr;
  logic [NUM_CH-1:0][CNT_W-1:0] cntArr;
  logic [NUM_CH-1:0]            rawVec;
  strobe_t                      strobes;

  pwmt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .VERSION(VERSION)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .cntArr(cntArr), .rawVec(rawVec),
    .ld1Arr(ld1Arr), .ld2Arr(ld2Arr), .ctlArr(ctlArr), .strobes(strobes)
  );

  pwmt_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .ld1Arr(ld1Arr), .ld2Arr(ld2Arr), .ctlArr(ctlArr),
    .strobes(strobes), .cntArr(cntArr), .rawVec(rawVec), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwmt_bank_chk.sv
module pwmt_bank_chk
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_CH-1:0][CNT_W-1:0] ld2Arr,
  input logic [NUM_CH-1:0][CTL_W-1:0] ctlArr,
  input logic [NUM_CH-1:0][CNT_W-1:0] cntArr,
  input logic [NUM_CH-1:0]            rawVec,
  input logic [NUM_CH-1:0]            pwmOut,
  input strobe_t                      strobes
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R6
    stopped_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      !ctlArr[g][CB_RUN] |-> !pwmOut[g]);

    // R6
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ctlArr[g][CB_RUN] && !strobes.start[g]) |=> cntArr[g] == $past(cntArr[g]));

    // R7
    raw_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rawVec[g]) |-> $past(ctlArr[g][CB_RUN] && cntArr[g] == '0));

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clr[g] && !(ctlArr[g][CB_RUN] && cntArr[g] == '0)) |=> !rawVec[g]);

    // R4
    high_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(pwmOut[g]) && $past(ctlArr[g][CB_RUN] && ctlArr[g][CB_USER] && ctlArr[g][CB_WAVE])
       && $stable(ld2Arr[g])) |-> cntArr[g] == ld2Arr[g]);

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes.start[g] |=> !pwmOut[g]);
  end
endmodule

bind pwmt_bank pwmt_bank_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .ld2Arr(ld2Arr), .ctlArr(ctlArr), .cntArr(cntArr),
  .rawVec(rawVec), .pwmOut(pwmOut), .strobes(strobes)
);

// File: tb/pwmt_bank_tb_top.sv
`timescale 1ns/1ps
module pwmt_bank_tb_top;
  localparam logic [31:0] VER = 32'h3230_372a;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic [7:0]  pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwmt_bank #(.VERSION(VER)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .pwmOut(pwmOut)
  );

  function automatic int ld1Ofs(input int ch);  return ch*20;      endfunction
  function automatic int curOfs(input int ch);  return ch*20 + 4;  endfunction
  function automatic int ctlOfs(input int ch);  return ch*20 + 8;  endfunction
  function automatic int ackOfs(input int ch);  return ch*20 + 12; endfunction
  function automatic int stsOfs(input int ch);  return ch*20 + 16; endfunction
  function automatic int ld2Ofs(input int ch);  return 176 + 4*ch; endfunction
  function automatic int phaseLen(input int ld); return ld + 1;    endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = 8'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 8'(a); rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic runLen(input int ch, input logic lvl, output int n);
    n = 0;
    while (pwmOut[ch] === lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pwmTrial(input int ch, input int lo, input int hi);
    int n;
    logic [31:0] d;
    wr(ctlOfs(ch), 32'h0);
    wr(ld1Ofs(ch), 32'(lo));
    wr(ld2Ofs(ch), 32'(hi));
    wr(ctlOfs(ch), 32'hb);
    runLen(ch, 1'b0, n); check("R4 first low", 32'(n), 32'(phaseLen(lo)));
    runLen(ch, 1'b1, n); check("R4 high", 32'(n), 32'(phaseLen(hi)));
    runLen(ch, 1'b0, n); check("R4 second low", 32'(n), 32'(phaseLen(lo)));
    wr(ctlOfs(ch), 32'h0);
    check("R6 stopped output", 32'(pwmOut[ch]), 32'h0);
    rd(ld2Ofs(ch), d); check("R2 second reload readback", d, 32'(hi));
    wr(ackOfs(ch), 32'h0);
    rd(ackOfs(ch), d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 outputs", 32'(pwmOut), 32'h0);
    rd(ld1Ofs(0), d);  check("R1 reload", d, 32'h0);
    rd(curOfs(3), d);  check("R1 count", d, 32'h0);
    rd(168, d);        check("R1 raw vector", d, 32'h0);
    rd(ld2Ofs(7), d);  check("R1 second reload", d, 32'h0);
    // R10
    rd(172, d);        check("R10 version", d, VER);

    // R2 map
    wr(ld1Ofs(7), 32'hdead_0007);
    wr(ld2Ofs(7), 32'hbeef_0077);
    rd(ld1Ofs(7), d);  check("R2 ch7 first reload", d, 32'hdead_0007);
    rd(ld2Ofs(7), d);  check("R2 ch7 second reload", d, 32'hbeef_0077);
    rd(ld1Ofs(6), d);  check("R2 neighbour untouched", d, 32'h0);

    // R3 / R6 count, no reload on re-enable, hold when stopped
    wr(ld1Ofs(1), 32'd10);
    wr(ctlOfs(1), 32'h3);
    repeat (3) @(negedge clk);
    rd(curOfs(1), d);  check("R3 count falls", d, 32'd7);
    wr(ctlOfs(1), 32'h3);
    rd(curOfs(1), d);  check("R6 no reload while running", d, 32'd5);
    wr(ctlOfs(1), 32'h2);
    rd(curOfs(1), d);  check("R6 stop count", d, 32'd3);
    repeat (5) @(negedge clk);
    rd(curOfs(1), d);  check("R6 count held", d, 32'd3);

    // R5 free-running reload
    wr(ld1Ofs(4), 32'd3);
    wr(ctlOfs(4), 32'h1);
    repeat (4) @(negedge clk);
    rd(curOfs(4), d);  check("R5 free reload all ones", d, 32'hffff_ffff);
    rd(curOfs(4), d);  check("R5 free keeps counting", d, 32'hffff_fffe);
    wr(ctlOfs(4), 32'h0);
    // R5 user mode without waveform
    wr(ld1Ofs(6), 32'd3);
    wr(ld2Ofs(6), 32'd9);
    wr(ctlOfs(6), 32'h3);
    repeat (4) @(negedge clk);
    rd(curOfs(6), d);  check("R5 user reload first value", d, 32'd3);
    wr(ctlOfs(6), 32'h0);

    // clear everything raised so far
    rd(164, d);        check("R9 global ack reads zero", d, 32'h0);
    rd(168, d);        check("R9 global ack clears all", d, 32'h0);

    // R7 / R8 / R9
    wr(ld1Ofs(2), 32'd3);
    wr(ctlOfs(2), 32'h3);
    repeat (6) @(negedge clk);
    wr(ctlOfs(2), 32'h0);
    rd(168, d);        check("R7 raw bit ch2", d, 32'h4);
    rd(160, d);        check("R8 unmasked vector", d, 32'h4);
    wr(ctlOfs(2), 32'h4);
    rd(160, d);        check("R8 masked vector", d, 32'h0);
    rd(stsOfs(2), d);  check("R8 masked channel status", d, 32'h0);
    rd(168, d);        check("R8 raw ignores mask", d, 32'h4);
    wr(ctlOfs(2), 32'h0);
    rd(stsOfs(2), d);  check("R8 channel status", d, 32'h1);
    wr(ld1Ofs(5), 32'd1);
    wr(ctlOfs(5), 32'h3);
    repeat (4) @(negedge clk);
    wr(ctlOfs(5), 32'h0);
    rd(168, d);        check("R7 raw two channels", d, 32'h24);
    rd(ackOfs(2), d);  check("R9 channel ack reads zero", d, 32'h0);
    rd(168, d);        check("R9 channel ack clears one", d, 32'h20);
    wr(ld1Ofs(3), 32'd0);
    wr(ctlOfs(3), 32'h3);
    repeat (3) @(negedge clk);
    wr(ctlOfs(3), 32'h0);
    rd(168, d);        check("R7 raw ch3 and ch5", d, 32'h28);
    rd(164, d);
    rd(168, d);        check("R9 global ack", d, 32'h0);

    // R4 directed corners
    pwmTrial(0, 0, 0);
    pwmTrial(3, 5, 2);
    pwmTrial(7, 40, 1);
    // R4 random
    for (int k = 0; k < 8; k++) begin
      pwmTrial(int'($urandom_range(7, 0)), int'($urandom_range(20, 0)), int'($urandom_range(20, 0)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule